// File: doc/BRIEF.md
# Paged Edge-Interrupt GPIO Controller

This block is a 48-line general-purpose I/O peripheral behind a small 16-byte register window with 8-bit data. The lines form six 8-bit ports. Writing a port offset loads that port's output latch, which drives the pads. Reading a port offset returns the pin levels after synchronization, not the latch. A line meant to be an input must have its latch bit at 0, so that an external driver can own the pin.

The lowest three ports (24 lines) can raise edge interrupts. Three per-line masks sit behind a shared three-byte window: an enable mask, an edge-polarity mask and the latched interrupt-ID bits. A page byte selects which of the three the window shows. A summary byte gives one pending bit per interrupt-capable port. A single active-high interrupt output stays asserted while any enabled line holds a latched edge. Software acknowledges a line by writing its enable bit to 0 and then back to 1. Clearing the enable bit discards the latched edge.

The bus is a plain synchronous strobe interface. A write takes effect at the clock edge where `bus_wr` is high. A read captures the addressed byte at the clock edge where `bus_rd` is high and holds it on `bus_rdata` until the next read.

Top module: `gpio48_edge_irq`

## Requirements
- R1: A write to offset p (0 to 5) loads `pins_out[8p+7:8p]` with the written byte after that clock edge. Other ports keep their value.
- R2: A read of offset p (0 to 5) returns the two-flop-synchronized levels of `pins_in[8p+7:8p]`, with line n at port n/8, bit n%8. The output latch value is not returned.
- R3: Offset 7 is the page byte. It reads back as written. The code 0x80 selects the enable page, 0x40 the polarity page and 0xC0 the ID page. With any other page code, offsets 8 to 10 read 0x00 and writes to them change nothing.
- R4: In the enable page, offsets 8, 9 and 10 read and write the enable masks of ports 0, 1 and 2. A 1 enables that line.
- R5: In the polarity page, offsets 8 to 10 read and write the polarity masks. A 1 latches a rising edge and a 0 latches a falling edge. An edge of the other direction, or an edge on a disabled line, latches nothing.
- R6: In the ID page, offsets 8 to 10 return the latched ID bits of ports 0 to 2. Writes to them are ignored.
- R7: Writing an enable bit to 0 clears that line's latched ID bit. Setting the enable bit back to 1 does not bring the bit back.
- R8: Offset 6 reads bit k (k = 0, 1, 2) as 1 when port k has any latched ID bit. Bits 7:3 read 0.
- R9: `irq_out` is 1 exactly while at least one latched ID bit is set. It stays 1 until all of them are cleared.
- R10: Offsets 11 to 15 read 0x00, and writes to them change nothing. Edges on lines 24 to 47 never latch an interrupt.
- R11: After reset, the output latches, enables, polarities, ID bits, page byte and read data are all 0, and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Byte captured by the last read |
| pins_in | input | 48 | Pin levels, asynchronous |
| pins_out | output | 48 | Output latch contents |
| irq_out | output | 1 | Shared interrupt, active high |

## Verification
The assertions assume that a write and a read never fall in the same cycle. They also assume that the bus offset is valid whenever a strobe is high. The edge checks rely on an edge reaching the interrupt logic only through the synchronizer, so they do not constrain how fast `pins_in` moves. The stimulus drives one strobe at a time, from the falling clock edge. After every pin change it holds `pins_in` steady for four cycles, so each change has settled through the synchronizer and the edge detector before the next bus access, and the bench model can score it as one step.

// File: rtl/gpio48_pkg.sv
package gpio48_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [3:0]  OFF_PEND = 4'd6;
    localparam logic [3:0]  OFF_PAGE = 4'd7;
    localparam logic [3:0]  OFF_WIN  = 4'd8;
    localparam logic [7:0]  CODE_EN  = 8'h80;
    localparam logic [7:0]  CODE_POL = 8'h40;
    localparam logic [7:0]  CODE_ID  = 8'hC0;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_EN,
        WIN_POL,
        WIN_ID
    } win_sel_e;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [3:0]  addr;
        logic [7:0]  data;
    } bus_req_t;

    function automatic win_sel_e page_decode(input logic [7:0] code);
        case (code)
            CODE_EN:  return WIN_EN;
            CODE_POL: return WIN_POL;
            CODE_ID:  return WIN_ID;
            default:  return WIN_NONE;
        endcase
    endfunction

    // Lines whose sampled transition matches the selected direction.
    function automatic logic [7:0] edge_hits(input logic [7:0] cur,
                                             input logic [7:0] old,
                                             input logic [7:0] rise_sel);
        return (cur & ~old & rise_sel) | (~cur & old & ~rise_sel);
    endfunction

endpackage

// File: rtl/gpio48_sync.sv
module gpio48_sync #(
    parameter int W      = 48,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] level_prev
);
    // Stage STAGES holds the previous synchronized sample for edge detection.
    logic [STAGES:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= raw;
            for (int s = 1; s <= STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign level      = stg[STAGES-1];
    assign level_prev = stg[STAGES];
endmodule

// File: rtl/gpio48_irq_bank.sv
module gpio48_irq_bank
    import gpio48_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic              pol_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] cur,
    input  logic [BYTE_W-1:0] old,
    output logic [BYTE_W-1:0] en_q,
    output logic [BYTE_W-1:0] pol_q,
    output logic [BYTE_W-1:0] id_q
);
    logic [BYTE_W-1:0] en_next;
    logic [BYTE_W-1:0] id_next;

    always_comb begin
        en_next = en_wr ? wdata : en_q;
        // A line disabled in this cycle drops its latched edge at once.
        id_next = (id_q | (edge_hits(cur, old, pol_q) & en_q)) & en_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pol_q <= '0;
            id_q  <= '0;
        end else begin
            en_q <= en_next;
            id_q <= id_next;
            if (pol_wr) begin
                pol_q <= wdata;
            end
        end
    end
endmodule

// File: rtl/gpio48_edge_irq.sv
module gpio48_edge_irq
    import gpio48_pkg::*;
#(
    parameter int PORTS       = 6,
    parameter int IRQ_PORTS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [3:0]                bus_addr,
    input  logic [7:0]                bus_wdata,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    output logic [7:0]                bus_rdata,
    input  logic [PORTS*BYTE_W-1:0]   pins_in,
    output logic [PORTS*BYTE_W-1:0]   pins_out,
    output logic                      irq_out
);
    localparam int LINES     = PORTS * BYTE_W;
    localparam int IRQ_LINES = IRQ_PORTS * BYTE_W;

    bus_req_t             req;
    logic [7:0]           page_q;
    win_sel_e             win;
    logic [LINES-1:0]     out_q;
    logic [LINES-1:0]     s_now;
    logic [LINES-1:0]     s_prev;
    logic [IRQ_LINES-1:0] en_all;
    logic [IRQ_LINES-1:0] pol_all;
    logic [IRQ_LINES-1:0] id_all;
    logic [IRQ_PORTS-1:0] pend;
    logic [7:0]           rd_val;
    logic [7:0]           rdata_q;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, data: bus_wdata};
    assign win = page_decode(page_q);

    // Page byte and output latches
    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            out_q  <= '0;
        end else if (req.wr) begin
            if (req.addr == OFF_PAGE) begin
                page_q <= req.data;
            end
            for (int p = 0; p < PORTS; p++) begin
                if (req.addr == 4'(p)) begin
                    out_q[p*BYTE_W +: BYTE_W] <= req.data;
                end
            end
        end
    end

    assign pins_out = out_q;

    gpio48_sync #(
        .W      (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst        (rst),
        .raw        (pins_in),
        .level      (s_now),
        .level_prev (s_prev)
    );

    for (genvar i = 0; i < IRQ_PORTS; i++) begin : g_irq
        logic win_hit;
        assign win_hit = req.wr && (req.addr == OFF_WIN + 4'(i));

        gpio48_irq_bank u_bank (
            .clk    (clk),
            .rst    (rst),
            .en_wr  (win_hit && (win == WIN_EN)),
            .pol_wr (win_hit && (win == WIN_POL)),
            .wdata  (req.data),
            .cur    (s_now[i*BYTE_W +: BYTE_W]),
            .old    (s_prev[i*BYTE_W +: BYTE_W]),
            .en_q   (en_all[i*BYTE_W +: BYTE_W]),
            .pol_q  (pol_all[i*BYTE_W +: BYTE_W]),
            .id_q   (id_all[i*BYTE_W +: BYTE_W])
        );

        assign pend[i] = |id_all[i*BYTE_W +: BYTE_W];
    end

    assign irq_out = |(id_all & en_all);

    // Read selection
    always_comb begin
        rd_val = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (req.addr == 4'(p)) begin
                rd_val = s_now[p*BYTE_W +: BYTE_W];
            end
        end
        if (req.addr == OFF_PEND) begin
            rd_val[IRQ_PORTS-1:0] = pend;
        end
        if (req.addr == OFF_PAGE) begin
            rd_val = page_q;
        end
        for (int i = 0; i < IRQ_PORTS; i++) begin
            if (req.addr == OFF_WIN + 4'(i)) begin
                case (win)
                    WIN_EN:  rd_val = en_all[i*BYTE_W +: BYTE_W];
                    WIN_POL: rd_val = pol_all[i*BYTE_W +: BYTE_W];
                    WIN_ID:  rd_val = id_all[i*BYTE_W +: BYTE_W];
                    default: rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.rd) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio48_checker.sv
module gpio48_checker #(
    parameter int LINES     = 48,
    parameter int IRQ_LINES = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic [3:0]           bus_addr,
    input logic [7:0]           bus_wdata,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [7:0]           bus_rdata,
    input logic [LINES-1:0]     pins_out,
    input logic                 irq_out,
    input logic [7:0]           page_q,
    input logic [IRQ_LINES-1:0] en_all,
    input logic [IRQ_LINES-1:0] pol_all,
    input logic [IRQ_LINES-1:0] id_all
);
    localparam int NPORT = LINES / 8;
    localparam int NIRQ  = IRQ_LINES / 8;

    a_r1_latch_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr < 4'(NPORT)))
        |=> (pins_out[8*$past(bus_addr) +: 8] == $past(bus_wdata)));

    a_r6_id_page_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (page_q == 8'hC0) && (bus_addr >= 4'd8) && (bus_addr < 4'(8 + NIRQ)))
        |=> ($stable(en_all) && $stable(pol_all)));

    a_r7_disable_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (page_q == 8'h80) && (bus_addr == 4'd8))
        |=> ((id_all[7:0] & ~$past(bus_wdata)) == 8'h00));

    a_r7_id_needs_enable: assert property (@(posedge clk) disable iff (rst)
        ((id_all & ~en_all) == '0));

    a_r5_no_latch_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((id_all & ~$past(id_all) & ~$past(en_all)) == '0));

    a_r9_irq_follows_ids: assert property (@(posedge clk) disable iff (rst)
        (irq_out == (id_all != '0)));

    a_r10_unused_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr >= 4'd11)) |=> (bus_rdata == 8'h00));
endmodule

bind gpio48_edge_irq gpio48_checker #(
    .LINES     (LINES),
    .IRQ_LINES (IRQ_LINES)
) u_chk (.*);

// File: tb/gpio48_edge_irq_bench.sv
module gpio48_edge_irq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [47:0] pins_in = '0;
    logic [47:0] pins_out;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model state
    logic [47:0] m_out  = '0;
    logic [47:0] m_pins = '0;
    logic [23:0] m_en   = '0;
    logic [23:0] m_pol  = '0;
    logic [23:0] m_id   = '0;
    logic [7:0]  m_page = '0;

    always #10 clk = ~clk;

    gpio48_edge_irq u_gpio48_edge_irq (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pins_in   (pins_in),
        .pins_out  (pins_out),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int a);
        if (a < 6) return m_pins[a*8 +: 8];
        if (a == 6) return {5'b0, |m_id[23:16], |m_id[15:8], |m_id[7:0]};
        if (a == 7) return m_page;
        if (a <= 10) begin
            case (m_page)
                8'h80:   return m_en[(a-8)*8 +: 8];
                8'h40:   return m_pol[(a-8)*8 +: 8];
                8'hC0:   return m_id[(a-8)*8 +: 8];
                default: return 8'h00;
            endcase
        end
        return 8'h00;
    endfunction

    function automatic string tag_of(input int a);
        if (a < 6)   return "R2 port read";
        if (a == 6)  return "R8 summary";
        if (a == 7)  return "R3 page";
        if (a <= 10) return "R6 window";
        return "R10 unused";
    endfunction

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = 4'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        if (a < 6) m_out[a*8 +: 8] = d;
        else if (a == 7) m_page = d;
        else if (a >= 8 && a <= 10) begin
            if (m_page == 8'h80) begin
                m_en[(a-8)*8 +: 8] = d;
                m_id[(a-8)*8 +: 8] &= d;
            end else if (m_page == 8'h40) begin
                m_pol[(a-8)*8 +: 8] = d;
            end
        end
    endtask

    task automatic do_read(input int a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = 4'(a);
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_model(input int a, input string tag);
        logic [7:0] v;
        do_read(a, v);
        chk(tag, {40'h0, v}, {40'h0, exp_read(a)});
    endtask

    task automatic rd_lit(input int a, input logic [7:0] e, input string tag);
        logic [7:0] v;
        do_read(a, v);
        chk(tag, {40'h0, v}, {40'h0, e});
    endtask

    task automatic set_pins(input logic [47:0] v);
        @(negedge clk);
        pins_in = v;
        for (int i = 0; i < 24; i++) begin
            if (m_en[i] && ((m_pol[i] && !m_pins[i] && v[i]) ||
                            (!m_pol[i] && m_pins[i] && !v[i]))) begin
                m_id[i] = 1'b1;
            end
        end
        m_pins = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5eed_c0de);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        for (int a = 0; a < 16; a++) rd_lit(a, 8'h00, "R11 reset read");
        chk("R11 reset pins_out", pins_out, 48'h0);
        chk("R11 reset irq", {47'h0, irq_out}, 48'h0);

        // R1 latch writes
        do_write(0, 8'hA5);
        do_write(5, 8'h3C);
        chk("R1 latch", pins_out, 48'h3C00_0000_00A5);

        // R2 reads return pins, not latch
        set_pins(48'h0000_0000_5A00);
        rd_lit(1, 8'h5A, "R2 port1 pins");
        rd_lit(0, 8'h00, "R2 port0 not latch");

        // R3 / R4 enable page
        do_write(7, 8'h80);
        rd_lit(7, 8'h80, "R3 page readback");
        do_write(8, 8'hFF);
        do_write(9, 8'h0F);
        rd_lit(8, 8'hFF, "R4 enable port0");
        rd_lit(9, 8'h0F, "R4 enable port1");

        // R5 polarity page
        do_write(7, 8'h40);
        do_write(8, 8'h0F);
        rd_lit(8, 8'h0F, "R5 polarity readback");

        // Rising edges on port0 bits 0-3
        do_write(7, 8'hC0);
        set_pins(48'h0000_0000_5AFF);
        rd_lit(8, 8'h0F, "R6 ID rising");
        rd_lit(6, 8'h01, "R8 summary port0");
        chk("R9 irq set", {47'h0, irq_out}, 48'h1);

        // Falling edges on bits 4-7 latch, bits 0-3 falling ignored (already set)
        set_pins(48'h0000_0000_5A00);
        rd_lit(8, 8'hFF, "R5 falling");
        // Port1 falling on bits 1,3,4,6; only 1,3 enabled
        set_pins(48'h0000_0000_0000);
        rd_lit(9, 8'h0A, "R5 enabled falling only");
        rd_lit(6, 8'h03, "R8 summary two ports");
        // Rising on port1 with falling polarity: nothing new
        set_pins(48'h0000_0000_FF00);
        rd_lit(9, 8'h0A, "R5 opposite edge ignored");

        // R6 writes in ID page ignored
        do_write(8, 8'h00);
        rd_lit(8, 8'hFF, "R6 ID write ignored");
        do_write(7, 8'h80);
        rd_lit(8, 8'hFF, "R6 enable untouched");

        // R7 acknowledge bit 0
        do_write(8, 8'hFE);
        do_write(8, 8'hFF);
        do_write(7, 8'hC0);
        rd_lit(8, 8'hFE, "R7 ack bit0");
        // Clear port0 entirely; port1 still pending
        do_write(7, 8'h80);
        do_write(8, 8'h00);
        do_write(8, 8'hFF);
        chk("R9 irq held", {47'h0, irq_out}, 48'h1);
        do_write(9, 8'h00);
        do_write(9, 8'h0F);
        chk("R9 irq cleared", {47'h0, irq_out}, 48'h0);
        do_write(7, 8'hC0);
        rd_lit(6, 8'h00, "R8 summary cleared");

        // R3 unknown page
        do_write(7, 8'h12);
        rd_lit(8, 8'h00, "R3 unknown page read");
        do_write(8, 8'h00);
        do_write(7, 8'h80);
        rd_lit(8, 8'hFF, "R3 unknown page write ignored");

        // R10 upper ports and unused offsets
        do_write(7, 8'hC0);
        set_pins(48'hFFFF_FF00_FF00);
        set_pins(48'h0000_0000_FF00);
        chk("R10 upper ports no irq", {47'h0, irq_out}, 48'h0);
        rd_lit(6, 8'h00, "R10 upper ports no pending");
        do_write(11, 8'hFF);
        do_write(15, 8'h5A);
        chk("R10 unused write", pins_out, m_out);
        for (int a = 11; a < 16; a++) rd_lit(a, 8'h00, "R10 unused read");

        // Random mix checked against the model
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: do_write(int'($urandom % 6), 8'($urandom));
                1: begin
                    logic [7:0] pg;
                    case ($urandom % 5)
                        0: pg = 8'h80;
                        1: pg = 8'h40;
                        2: pg = 8'hC0;
                        3: pg = 8'h00;
                        default: pg = 8'($urandom);
                    endcase
                    do_write(7, pg);
                end
                2: do_write(8 + int'($urandom % 3), 8'($urandom));
                3: set_pins(m_pins ^ {16'($urandom), 32'($urandom)});
                4: do_write(11 + int'($urandom % 5), 8'($urandom));
                default: ;
            endcase
            begin
                int a;
                a = int'($urandom % 16);
                rd_model(a, tag_of(a));
            end
            chk("R9 random irq", {47'h0, irq_out}, {47'h0, |m_id});
            chk("R1 random latch", pins_out, m_out);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule